// File: doc/BRIEF.md
# Asynchronous SRAM Write-Cycle Controller

This block turns a one-beat write request from a synchronous host into a complete write cycle on the pins of an asynchronous static RAM. The cycle is timed by the write-enable edges. Chip enable falls first. Write enable is then pulsed low while the controller drives the data bus. After write enable rises, chip enable and the bus driver are released. Output enable is never asserted, so the memory's own outputs stay high-impedance and the controller can drive the shared bus at any time without contention.

Each memory timing limit is a parameter counted in whole clock periods, and each one is rounded up. Chip-enable lead is `SETUP_CYC`, at least 1. The write-enable low time is the larger of `WE_LOW_CYC` and `DATA_SETUP_CYC`, because data is driven for exactly as long as write enable is low. The minimum spacing between address changes is `CYCLE_CYC`.

The host side is a valid/ready stream. A request is taken on a clock edge where both `req_valid` and `req_ready` are high. While `req_ready` is low, the host keeps `req_valid`, `req_addr` and `req_data` stable. A request held off in this way is taken as soon as `req_ready` returns, and it is not lost.

Top module: `sram_wr_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `req_ready`=1, `mem_ce_n`=1, `mem_we_n`=1, `mem_oe_n`=1 and `mem_dq_oe`=0.
- R2: `mem_oe_n` is 1 in every cycle, so the memory never drives the bus while `mem_dq_oe` is 1.
- R3: `mem_we_n` is 0 only while `mem_ce_n` is 0. `mem_ce_n` stays 0 in the cycle in which `mem_we_n` returns to 1, and it rises exactly one cycle after `mem_we_n` rises.
- R4: `mem_addr` and `mem_ce_n` change only at acceptance. `mem_ce_n` is 0 for exactly max(`SETUP_CYC`,1) cycles before `mem_we_n` falls, and `mem_addr` stays stable while `mem_ce_n` is 0.
- R5: `mem_we_n` stays 0 for exactly max(`WE_LOW_CYC`,`DATA_SETUP_CYC`,1) cycles per write.
- R6: `mem_dq_oe` rises in the same cycle that `mem_we_n` falls and falls one cycle after `mem_we_n` rises. While `mem_dq_oe` is 1, `mem_dq_out` holds the accepted data unchanged.
- R7: After acceptance, `req_ready` is 0 for exactly P-1 cycles, where P = max(S+L+2, `CYCLE_CYC`), S is the chip-enable lead of R4 and L is the low time of R5. Two acceptances are therefore at least P cycles apart.
- R8: A request presented while `req_ready` is 0 is not taken. It is accepted on the first edge at which `req_ready` is 1, so with `req_valid` held high, acceptances are exactly P cycles apart.
- R9: Each accepted request writes its data to its address exactly once. When several requests go to the same address, the last one accepted determines the stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host write request valid |
| req_ready | output | 1 | Controller can take a request |
| req_addr | input | ADDR_W | Write address |
| req_data | input | DATA_W | Write data |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low, held inactive |
| mem_dq_out | output | DATA_W | Value driven onto the memory data bus |
| mem_dq_oe | output | 1 | Data bus driver enable, active high |

## Verification
The bench builds the controller with `SETUP_CYC`=2, `WE_LOW_CYC`=2, `DATA_SETUP_CYC`=3 and `CYCLE_CYC`=9. With these values the data-setup limit, not the pulse limit, sets the write-enable width, the chip-enable lead is longer than one cycle, and a padding phase must run before `req_ready` returns. This exercises every branch of the phase sequence. A 4-bit address keeps the behavioural memory small enough to sweep through the backdoor after back-to-back writes, held-off requests and an overwrite of one address.

// File: rtl/sram_wr_pkg.sv
package sram_wr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_LOW   = 3'd2,
    ST_HOLD  = 3'd3,
    ST_PAD   = 3'd4
  } wr_state_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_wr_timer.sv
module sram_wr_timer #(
  parameter int TW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          last
);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (load)            cnt_q <= load_val;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign last = (cnt_q == '0);

endmodule

// File: rtl/sram_wr_seq.sv
module sram_wr_seq
  import sram_wr_pkg::*;
#(
  parameter int S_LEN     = 1,
  parameter int L_LEN     = 3,
  parameter int PAD_LEN   = 0,
  parameter int CYCLE_CYC = 3,
  parameter int TW        = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  output logic          accept,
  output wr_state_e     state_nxt,
  output logic          tmr_load,
  output logic [TW-1:0] tmr_val,
  input  logic          tmr_last
);

  localparam int PAD_LD = (PAD_LEN > 0) ? PAD_LEN - 1 : 0;

  wr_state_e state_q;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;

  always_comb begin
    state_nxt = state_q;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    case (state_q)
      ST_IDLE: if (accept) begin
        state_nxt = ST_SETUP;
        tmr_load  = 1'b1;
        tmr_val   = TW'(S_LEN - 1);
      end
      ST_SETUP: if (tmr_last) begin
        state_nxt = ST_LOW;
        tmr_load  = 1'b1;
        tmr_val   = TW'(L_LEN - 1);
      end
      ST_LOW: if (tmr_last) state_nxt = ST_HOLD;
      ST_HOLD: begin
        if (PAD_LEN > 0) begin
          state_nxt = ST_PAD;
          tmr_load  = 1'b1;
          tmr_val   = TW'(PAD_LD);
        end else begin
          state_nxt = ST_IDLE;
        end
      end
      ST_PAD: if (tmr_last) state_nxt = ST_IDLE;
      default: state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_nxt;
  end

  // checker state: cycles since the last acceptance
  int unsigned since_acc_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        since_acc_q <= '0;
    else if (accept)                   since_acc_q <= 1;
    else if (since_acc_q < 32'h7fff_ffff) since_acc_q <= since_acc_q + 1;
  end

  // R7: ready drops right after a request is taken
  p_ready_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);

  // R7: ready comes back no earlier than the minimum cycle time
  p_busy_span_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_ready) |-> (since_acc_q >= CYCLE_CYC));

endmodule

// File: rtl/sram_wr_pins.sv
module sram_wr_pins
  import sram_wr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int S_LEN  = 1,
  parameter int L_LEN  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  wr_state_e         state_nxt,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr   <= '0;
      mem_dq_out <= '0;
      mem_ce_n   <= 1'b1;
      mem_we_n   <= 1'b1;
      mem_dq_oe  <= 1'b0;
    end else begin
      mem_ce_n  <= !(state_nxt inside {ST_SETUP, ST_LOW, ST_HOLD});
      mem_we_n  <= (state_nxt != ST_LOW);
      mem_dq_oe <= (state_nxt inside {ST_LOW, ST_HOLD});
      if (accept) begin
        mem_addr   <= req_addr;
        mem_dq_out <= req_data;
      end
    end
  end

  // output enable never asserted: memory outputs stay high-impedance
  assign mem_oe_n = 1'b1;

  // checker counters
  int unsigned ce_lead_q;
  int unsigned we_low_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_lead_q <= '0;
      we_low_q  <= '0;
    end else begin
      if (mem_ce_n)      ce_lead_q <= '0;
      else if (mem_we_n) ce_lead_q <= ce_lead_q + 1;
      if (mem_we_n)      we_low_q  <= '0;
      else               we_low_q  <= we_low_q + 1;
    end
  end

  p_we_inside_ce_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_ce_n);

  p_ce_after_we_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> !mem_ce_n);

  p_ce_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |=> mem_ce_n);

  p_ce_lead_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> (ce_lead_q == S_LEN));

  p_addr_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

  p_we_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_low_q == L_LEN));

  p_drv_on_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> $rose(mem_dq_oe));

  p_drv_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |=> $fell(mem_dq_oe));

  p_data_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out));

endmodule

// File: rtl/sram_wr_ctrl.sv
module sram_wr_ctrl
  import sram_wr_pkg::*;
#(
  parameter int ADDR_W         = 16,
  parameter int DATA_W         = 16,
  parameter int SETUP_CYC      = 1,
  parameter int WE_LOW_CYC     = 3,
  parameter int DATA_SETUP_CYC = 2,
  parameter int CYCLE_CYC      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe
);

  localparam int S_LEN   = imax(SETUP_CYC, 1);
  localparam int L_LEN   = imax(imax(WE_LOW_CYC, DATA_SETUP_CYC), 1);
  localparam int PAD_LEN = imax(CYCLE_CYC - S_LEN - L_LEN - 2, 0);
  localparam int LONGEST = imax(imax(S_LEN, L_LEN), imax(PAD_LEN, 1));
  localparam int TW      = $clog2(LONGEST + 1);

  wr_state_e     state_nxt;
  logic          accept;
  logic          tmr_load;
  logic [TW-1:0] tmr_val;
  logic          tmr_last;

  sram_wr_timer #(.TW(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .last     (tmr_last)
  );

  sram_wr_seq #(
    .S_LEN     (S_LEN),
    .L_LEN     (L_LEN),
    .PAD_LEN   (PAD_LEN),
    .CYCLE_CYC (CYCLE_CYC),
    .TW        (TW)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .accept    (accept),
    .state_nxt (state_nxt),
    .tmr_load  (tmr_load),
    .tmr_val   (tmr_val),
    .tmr_last  (tmr_last)
  );

  sram_wr_pins #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .S_LEN  (S_LEN),
    .L_LEN  (L_LEN)
  ) u_pins (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .req_addr   (req_addr),
    .req_data   (req_data),
    .state_nxt  (state_nxt),
    .mem_addr   (mem_addr),
    .mem_ce_n   (mem_ce_n),
    .mem_we_n   (mem_we_n),
    .mem_oe_n   (mem_oe_n),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe)
  );

endmodule

// File: tb/sram_wr_ctrl_bench.sv
module sram_wr_ctrl_bench;

  localparam int AW = 4;
  localparam int DW = 8;
  localparam int S_EXP = 2;   // max(SETUP_CYC,1)
  localparam int L_EXP = 3;   // max(2,3)
  localparam int P_EXP = 9;   // max(2+3+2, 9)
  localparam int NVEC  = 6;
  localparam logic [AW+DW-1:0] VEC [NVEC] = '{
    {4'h0, 8'h11}, {4'hF, 8'hFF}, {4'h3, 8'hA5},
    {4'h7, 8'h00}, {4'h3, 8'h5A}, {4'hA, 8'h3C}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid;
  logic          req_ready;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_data;
  logic [AW-1:0] mem_addr;
  logic          mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [DW-1:0] mem_dq_out;

  always #4 clk = ~clk;

  sram_wr_ctrl #(
    .ADDR_W(AW), .DATA_W(DW), .SETUP_CYC(2), .WE_LOW_CYC(2),
    .DATA_SETUP_CYC(3), .CYCLE_CYC(9)
  ) u_sram_wr_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_data(req_data), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // behavioural memory and expected contents
  logic [DW-1:0] model   [1<<AW];
  logic [DW-1:0] exp_mem [1<<AW];
  int n_writes = 0;

  // monitor state
  bit mon_en = 0;
  bit exact_gap = 0;
  bit prev_we = 1, prev_ce = 1, prev_rdy = 1;
  int cyc = 0, ce_pre = 0, we_run = 0, we_rise_cyc = -10;
  int last_acc = -1, rdy_low = 0;
  logic [DW-1:0] dq_at_fall;
  logic [AW-1:0] addr_at_fall;

  always @(negedge clk) begin
    if (rst_n && mon_en) begin
      cyc++;
      chk(mem_oe_n == 1'b1, "R2", "oe_n high", mem_oe_n, 1);
      if (!mem_we_n) chk(!mem_ce_n, "R3", "ce_n low while we_n low", mem_ce_n, 0);
      if (prev_we && !mem_we_n) begin
        chk(ce_pre == S_EXP, "R4", "ce lead cycles", ce_pre, S_EXP);
        chk(mem_dq_oe, "R6", "driver on at we fall", mem_dq_oe, 1);
        dq_at_fall = mem_dq_out;
        addr_at_fall = mem_addr;
        we_run = 1;
      end else if (!prev_we && !mem_we_n) begin
        we_run++;
      end
      if (!prev_we && mem_we_n) begin
        chk(we_run == L_EXP, "R5", "we low cycles", we_run, L_EXP);
        chk(!mem_ce_n, "R3", "ce_n low at we rise", mem_ce_n, 0);
        chk(mem_dq_oe, "R6", "driver held at we rise", mem_dq_oe, 1);
        chk(mem_dq_out == dq_at_fall, "R6", "data stable", mem_dq_out, dq_at_fall);
        chk(mem_addr == addr_at_fall, "R4", "addr stable", mem_addr, addr_at_fall);
        if (!mem_ce_n && mem_dq_oe) begin
          model[mem_addr] = mem_dq_out;
          n_writes++;
        end
        we_rise_cyc = cyc;
      end
      if (!prev_ce && mem_ce_n) begin
        chk(cyc - we_rise_cyc == 1, "R3", "ce release delay", cyc - we_rise_cyc, 1);
        chk(!mem_dq_oe, "R6", "driver off after we rise", mem_dq_oe, 0);
      end
      if (mem_ce_n) ce_pre = 0;
      else if (mem_we_n) ce_pre++;
      if (!req_ready) rdy_low++;
      else if (!prev_rdy) begin
        chk(rdy_low == P_EXP - 1, "R7", "ready low cycles", rdy_low, P_EXP - 1);
        rdy_low = 0;
      end
      if (req_valid && req_ready) begin
        if (last_acc >= 0) begin
          if (exact_gap) chk(cyc - last_acc == P_EXP, "R8", "held request gap", cyc - last_acc, P_EXP);
          else           chk(cyc - last_acc >= P_EXP, "R7", "accept spacing", cyc - last_acc, P_EXP);
        end
        last_acc = cyc;
      end
      prev_we = mem_we_n;
      prev_ce = mem_ce_n;
      prev_rdy = req_ready;
    end
  end

  // called just after a negedge; returns just after the negedge following acceptance
  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    req_valid = 1'b1;
    req_addr  = a;
    req_data  = d;
    while (!req_ready) begin
      @(negedge clk); #1;
    end
    @(negedge clk); #1;
    exp_mem[a] = d;
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    for (int i = 0; i < (1 << AW); i++) begin
      model[i] = '0;
      exp_mem[i] = '0;
    end
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_data = '0;
    repeat (3) @(negedge clk);
    // R1: reset values
    chk(req_ready == 1'b1, "R1", "ready in reset", req_ready, 1);
    chk(mem_ce_n == 1'b1, "R1", "ce_n in reset", mem_ce_n, 1);
    chk(mem_we_n == 1'b1, "R1", "we_n in reset", mem_we_n, 1);
    chk(mem_oe_n == 1'b1, "R1", "oe_n in reset", mem_oe_n, 1);
    chk(mem_dq_oe == 1'b0, "R1", "dq_oe in reset", mem_dq_oe, 0);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && mem_ce_n && mem_we_n && !mem_dq_oe, "R1", "idle after reset",
        {req_ready, mem_ce_n, mem_we_n, mem_dq_oe}, 4'b1110);
    #1 mon_en = 1'b1;
    repeat (4) @(negedge clk);
    chk(mem_ce_n == 1'b1, "R4", "no cycle without request", mem_ce_n, 1);
    #1;

    // vector table walked back to back
    exact_gap = 1'b1;
    for (int i = 0; i < NVEC; i++) begin
      do_write(VEC[i][AW+DW-1:DW], VEC[i][DW-1:0]);
    end
    req_valid = 1'b0;
    exact_gap = 1'b0;
    repeat (12) @(negedge clk); #1;

    // isolated write, boundary data
    do_write(4'h5, 8'h77);
    req_valid = 1'b0;
    repeat (2) @(negedge clk); #1;
    // request raised mid-cycle is held off, then taken on first ready
    chk(req_ready == 1'b0, "R8", "busy before held request", req_ready, 0);
    exact_gap = 1'b0;
    do_write(4'h9, 8'h42);
    req_valid = 1'b0;
    repeat (2) @(negedge clk); #1;
    exact_gap = 1'b1;
    do_write(4'hC, 8'h99);
    req_valid = 1'b0;
    exact_gap = 1'b0;
    repeat (14) @(negedge clk);

    // R9: backdoor comparison of the memory model
    for (int i = 0; i < (1 << AW); i++) begin
      chk(model[i] == exp_mem[i], "R9", $sformatf("word %0d", i), model[i], exp_mem[i]);
    end
    chk(n_writes == NVEC + 3, "R9", "write count", n_writes, NVEC + 3);
    chk(mem_ce_n && req_ready, "R7", "idle at end", {mem_ce_n, req_ready}, 2'b11);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 20000, 0);
      summary();
      $finish;
    end
  end

endmodule